// File: doc/BRIEF.md
# Programmable Watchdog Timer with Reset/Interrupt Steering

This block is a watchdog timer controlled through a single 8-bit configuration register. The register holds three fields. The low two bits are a resolution code and the next five bits are a multiplier. The top bit is a steering bit that selects what happens when the timer expires. The count advances on a 16 Hz tick strobe, so one count is one sixteenth of a second. The timeout, in ticks, is the multiplier times four raised to the resolution code. The four resolutions are therefore 1/16 s, 1/4 s, 1 s and 4 s per multiplier step.

Software restarts (kicks) the timer by writing the register or by reading it. A read reloads the count from the value already stored. Every restart clears the timeout flag. On expiry the flag is set. If the steering bit is set, the block does three things: it raises a one-cycle system reset request, it clears the configuration register to zero, and it raises a one-cycle strobe that tells the neighbouring calendar register to clear its century bit. If the steering bit is clear, the block raises a single interrupt pulse, and the count stays halted until the next restart.

Top module: `wdog_steer`

## Requirements
- R1: After synchronous reset, `cfg_q` is 0x00 and `wd_flag`, `sys_rst_req`, `century_clr` and `irq_pulse` are all 0.
- R2: A write stores `cfg_wdata` into `cfg_q` and loads the count. With multiplier M = bits 6:2 and resolution R = bits 1:0, expiry occurs on exactly the (M << 2R)-th tick after the write, and on no earlier tick.
- R3: When the multiplier field is zero (this includes the all-zero value), no tick ever causes an expiry.
- R4: A read strobe on `cfg_rd` reloads the full timeout from the stored value, without changing `cfg_q`.
- R5: Every restart, by write or by read, clears `wd_flag` on the following cycle.
- R6: Expiry sets `wd_flag`, and the flag stays set until the next restart.
- R7: At expiry with bit 7 set, `sys_rst_req` and `century_clr` are each high for exactly one cycle, `cfg_q` becomes 0x00, and `irq_pulse` stays low.
- R8: At expiry with bit 7 clear, `irq_pulse` is high for exactly one cycle and `sys_rst_req` stays low. No further interrupt occurs on later ticks until a restart.
- R9: A restart in the same cycle as an expiring tick wins. No expiry occurs, and the count reloads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration register (restarts the count) |
| cfg_rd | input | 1 | Read strobe for the configuration register (restarts the count) |
| cfg_wdata | input | 8 | Write data: bit 7 steering, bits 6:2 multiplier, bits 1:0 resolution |
| tick16 | input | 1 | One-cycle strobe at 16 Hz |
| cfg_q | output | 8 | Current register contents (read data) |
| wd_flag | output | 1 | Timeout flag for the flags register |
| sys_rst_req | output | 1 | One-cycle system reset request |
| century_clr | output | 1 | One-cycle strobe that clears the century bit held elsewhere |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The embedded assertions check the following on every cycle:
- The reset request and the century-clear strobe last exactly one cycle.
- The reset request and the interrupt are never high together.
- A restart always drops the flag.
- An interrupt is always accompanied by the flag.
- The configuration register reads zero after a reset-steered expiry.
- A halted counter stays halted until it is reloaded.

Only the bench scenarios can show the following:
- The exact tick on which each multiplier and resolution combination expires.
- That a zero multiplier never expires.
- That a read kick reloads the full timeout.
- That a kick wins over an expiring tick in the same cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    STEER_IRQ   = 1'b0,
    STEER_RESET = 1'b1
  } steer_e;
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  localparam int REG_W = MULT_W + RES_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [REG_W-1:0] wdata,
  input  logic             clr,
  output logic [REG_W-1:0] q,
  output logic             restart,
  output logic [REG_W-1:0] load_val
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (wr)   q <= wdata;
    else if (clr)  q <= '0;
  end

  assign restart  = wr | rd;
  assign load_val = wr ? wdata : q;

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (clr && !wr) |=> (q == '0)); // R7
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr && !clr) |=> $stable(q)); // R4
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  localparam int REG_W = MULT_W + RES_W + 1,
  localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REG_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0]  cnt;
  logic              run;
  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res;
  logic [CNT_W-1:0]  span;

  assign res  = load_val[RES_W-1:0];
  assign mult = load_val[RES_W +: MULT_W];
  assign span = CNT_W'(mult) << {res, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= span;
      run <= (mult != '0);
    end else if (tick && run) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) run <= 1'b0;
    end
  end

  assign expire = tick & run & ~load & (cnt == CNT_W'(1));

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> !run); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0)); // R2
  AST_ZERO_MULT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (load && mult == '0) |=> !run); // R3
endmodule

// File: rtl/wdog_action.sv
module wdog_action
  import wdog_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   expire,
  input  steer_e steer,
  input  logic   restart,
  output logic   flag,
  output logic   rst_req,
  output logic   cent_clr,
  output logic   irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      rst_req  <= 1'b0;
      cent_clr <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (restart)     flag <= 1'b0;
      else if (expire) flag <= 1'b1;
      rst_req  <= expire && (steer == STEER_RESET);
      cent_clr <= expire && (steer == STEER_RESET);
      irq      <= expire && (steer == STEER_IRQ);
    end
  end

  AST_FLAG_DROPS: assert property (@(posedge clk) disable iff (rst)
    restart |=> !flag); // R5
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req); // R7
  AST_CENT_WITH_RST: assert property (@(posedge clk) disable iff (rst)
    cent_clr == rst_req); // R7
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R8
  AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag); // R6
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(irq && rst_req)); // R8
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
  import wdog_pkg::*;
#(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  localparam int REG_W = MULT_W + RES_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             tick16,
  output logic [REG_W-1:0] cfg_q,
  output logic             wd_flag,
  output logic             sys_rst_req,
  output logic             century_clr,
  output logic             irq_pulse
);
  logic             restart;
  logic             expire;
  logic [REG_W-1:0] load_val;
  steer_e           steer;

  assign steer = steer_e'(cfg_q[REG_W-1]);

  wdog_cfg #(.MULT_W(MULT_W), .RES_W(RES_W)) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .rd(cfg_rd), .wdata(cfg_wdata),
    .clr(expire && steer == STEER_RESET), .q(cfg_q),
    .restart(restart), .load_val(load_val)
  );

  wdog_counter #(.MULT_W(MULT_W), .RES_W(RES_W)) u_cnt (
    .clk(clk), .rst(rst), .load(restart), .load_val(load_val),
    .tick(tick16), .expire(expire)
  );

  wdog_action u_act (
    .clk(clk), .rst(rst), .expire(expire), .steer(steer),
    .restart(restart), .flag(wd_flag), .rst_req(sys_rst_req),
    .cent_clr(century_clr), .irq(irq_pulse)
  );

  AST_RST_CLEARS_CFG: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> (cfg_q == '0)); // R7
endmodule

// File: tb/wdog_steer_test.sv
module wdog_steer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0, cfg_rd = 1'b0, tick16 = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_q;
  logic wd_flag, sys_rst_req, century_clr, irq_pulse;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wdog_steer uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_wdata(cfg_wdata), .tick16(tick16), .cfg_q(cfg_q),
    .wd_flag(wd_flag), .sys_rst_req(sys_rst_req),
    .century_clr(century_clr), .irq_pulse(irq_pulse)
  );

  localparam int NVEC = 7;
  localparam logic [7:0] VEC [NVEC] = '{8'h04, 8'h0D, 8'h7C, 8'h0A, 8'h07, 8'h12, 8'h7F};

  function automatic int span_of(input logic [7:0] v);
    return int'(v[6:2]) << (2 * int'(v[1:0]));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); cfg_rd = 1'b1;
    @(negedge clk); cfg_rd = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk); tick16 = 1'b1;
    @(negedge clk); tick16 = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    int early;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cfg", cfg_q, 0);
    chk("R1 outs", {wd_flag, sys_rst_req, century_clr, irq_pulse}, 0);

    // R2 table walk: interrupt steering, expiry at exactly M<<2R ticks
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i]);
      chk("R2 stored", cfg_q, VEC[i]);
      chk("R5 flag after write", wd_flag, 0);
      early = 0;
      for (int t = 1; t < span_of(VEC[i]); t++) begin
        tk();
        if (irq_pulse || sys_rst_req || wd_flag) early++;
      end
      chk("R2 no early expiry", early, 0);
      tk();
      chk("R2 irq at expiry", irq_pulse, 1);
      chk("R8 no reset req", sys_rst_req, 0);
      chk("R6 flag set", wd_flag, 1);
      @(negedge clk);
      chk("R8 one-cycle irq", irq_pulse, 0);
    end

    // R8 halted after interrupt, R6 flag holds
    early = 0;
    for (int t = 0; t < 5; t++) begin
      tk();
      if (irq_pulse) early++;
    end
    chk("R8 no repeat irq", early, 0);
    chk("R6 flag held", wd_flag, 1);

    // R3 zero multiplier never expires
    wr(8'h00);
    early = 0;
    for (int t = 0; t < 300; t++) begin tk(); if (irq_pulse || sys_rst_req || wd_flag) early++; end
    chk("R3 zero value idle", early, 0);
    wr(8'h83);
    early = 0;
    for (int t = 0; t < 300; t++) begin tk(); if (irq_pulse || sys_rst_req || wd_flag) early++; end
    chk("R3 zero multiplier idle", early, 0);
    chk("R3 cfg kept", cfg_q, 8'h83);

    // R4 read kick reloads full timeout
    wr(8'h0C);
    tk(); tk();
    rd();
    chk("R4 read keeps cfg", cfg_q, 8'h0C);
    early = 0;
    tk(); if (irq_pulse) early++;
    tk(); if (irq_pulse) early++;
    chk("R4 no expiry after read kick", early, 0);
    tk();
    chk("R4 expiry after reload", irq_pulse, 1);
    rd();
    chk("R5 read clears flag", wd_flag, 0);

    // R9 kick wins over expiring tick
    wr(8'h04);
    @(negedge clk); tick16 = 1'b1; cfg_wr = 1'b1; cfg_wdata = 8'h08;
    @(negedge clk); tick16 = 1'b0; cfg_wr = 1'b0;
    chk("R9 no irq on collision", irq_pulse, 0);
    chk("R9 flag clear", wd_flag, 0);
    tk();
    chk("R9 no irq after one tick", irq_pulse, 0);
    tk();
    chk("R9 irq after reload span", irq_pulse, 1);

    // R7 reset steering
    wr(8'h85);
    early = 0;
    for (int t = 1; t < 4; t++) begin tk(); if (sys_rst_req || irq_pulse) early++; end
    chk("R7 no early reset", early, 0);
    tk();
    chk("R7 reset request", sys_rst_req, 1);
    chk("R7 century clear", century_clr, 1);
    chk("R7 irq low", irq_pulse, 0);
    chk("R7 cfg cleared", cfg_q, 0);
    chk("R7 flag set", wd_flag, 1);
    @(negedge clk);
    chk("R7 one-cycle reset", {sys_rst_req, century_clr}, 0);

    // R1 reset again mid-run
    wr(8'h08);
    tk();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset clears cfg", cfg_q, 0);
    tk(); tk();
    chk("R1 no expiry after reset", irq_pulse, 0);

    summary();
  end
endmodule